// File: doc/BRIEF.md
# FIFO Trigger Level and Fill Count Register Port

This block is the register-side logic that sits between a byte-wide host bus and a pair of 128-entry transmit and receive FIFOs. One bus address serves two registers: a write to it loads a user trigger level, and a read from it returns the number of characters held in a FIFO. A direction bit in the block's own feature register decides which FIFO both operations target: the receive side or the transmit side. The feature register also carries a two-bit trigger-table selector and a two-bit flow-control hysteresis field.

For each direction the block picks an effective trigger threshold. The selector chooses one of three fixed levels, which are set by parameters, or the user-programmed level. It also raises a threshold flag when the FIFO fill count crosses that level. Both registers can be reached only while the line control value presented to the block equals the unlock key 0xBF. Reads are combinational and writes take effect at the clock edge. There is no data stream at the block's edge, so every pin is a plain control or status signal.

Top module: `fifo_trig_port`

## Requirements
- R1: After reset the feature register reads 0x00, both user trigger levels are 0x00, and the hysteresis output is 0.
- R2: With the line control input at 0xBF, a write to address 0 loads the RX user level when feature bit 7 is 0, and the TX user level when feature bit 7 is 1. The other level is left unchanged.
- R3: With the line control input at 0xBF, a read of address 0 returns the RX fill count when feature bit 7 is 0 and the TX fill count when it is 1. A full FIFO (128) reads as 0x80.
- R4: Writes to address 0 or address 1 made while the line control input is not 0xBF change neither user level nor the feature register.
- R5: Reads made while the line control input is not 0xBF, and reads of any address other than 0 or 1, return 0x00.
- R6: Feature bits [5:4] choose the effective level for both directions. 00, 01 and 10 select the fixed levels: RX 8, 16 and 56; TX 8, 16 and 32. 11 selects the user level of that direction.
- R7: The RX flag is high exactly when the RX count is greater than or equal to the effective RX level.
- R8: The TX flag is high exactly when the TX count is less than or equal to the effective TX level.
- R9: The feature register is written and read at address 1 while unlocked, and the hysteresis output always equals its bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| lcr_val | input | 8 | Current line control register value |
| rx_count | input | 8 | RX FIFO fill count, 0 to 128 |
| tx_count | input | 8 | TX FIFO fill count, 0 to 128 |
| rx_level | output | 8 | Effective RX trigger level |
| tx_level | output | 8 | Effective TX trigger level |
| rx_hit | output | 1 | RX count at or above its level |
| tx_hit | output | 1 | TX count at or below its level |
| rts_hyst | output | 2 | Flow-control hysteresis selection |

## Verification
A user level or feature bit that holds a wrong value shows at the ports in the first cycle after the write. It appears on the level outputs once table 11 is selected, and the flags then move with it. A direction bit that steers a write to the wrong side shows as the untouched level changing. The same fault on a read shows as the count of the other FIFO on the read data, with no latency, because the read path has no register. The random stimulus keeps the two counts different from each other so that such swaps stay visible.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam logic [7:0] LCR_KEY = 8'hBF;

  typedef enum logic [1:0] {
    TBL_A    = 2'b00,
    TBL_B    = 2'b01,
    TBL_C    = 2'b10,
    TBL_USER = 2'b11
  } tbl_sel_e;

  typedef struct packed {
    logic       dir_tx;
    logic       spare6;
    tbl_sel_e   tbl;
    logic [1:0] spare32;
    logic [1:0] hyst;
  } feat_t;
endpackage

// File: rtl/ftc_feat_reg.sv
module ftc_feat_reg
  import ftc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output feat_t       feat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     feat_q <= '0;
    else if (wr_en) feat_q <= feat_t'(wdata);
  end
endmodule

// File: rtl/ftc_trig_bank.sv
module ftc_trig_bank #(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       dir_tx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [1:0][DATA_W-1:0]     user_q
);
  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic hit_dir;
    assign hit_dir = wr_en && (dir_tx == (d == 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       user_q[d] <= '0;
      else if (hit_dir) user_q[d] <= wdata;
    end
  end
endmodule

// File: rtl/ftc_level_sel.sv
module ftc_level_sel
  import ftc_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [3*DATA_W-1:0] FIXED  = '0
) (
  input  tbl_sel_e             tbl,
  input  logic [DATA_W-1:0]    user_lvl,
  output logic [DATA_W-1:0]    level
);
  always_comb begin
    unique case (tbl)
      TBL_A:   level = FIXED[0*DATA_W +: DATA_W];
      TBL_B:   level = FIXED[1*DATA_W +: DATA_W];
      TBL_C:   level = FIXED[2*DATA_W +: DATA_W];
      default: level = user_lvl;
    endcase
  end
endmodule

// File: rtl/ftc_thresh.sv
module ftc_thresh #(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter bit AT_HIGH = 1'b1
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] level,
  output logic              hit
);
  localparam int CMP_W = (CNT_W > DATA_W) ? CNT_W : DATA_W;
  logic [CMP_W-1:0] c_ext, l_ext;
  assign c_ext = CMP_W'(count);
  assign l_ext = CMP_W'(level);

  if (AT_HIGH) begin : g_high
    assign hit = (c_ext >= l_ext);
  end else begin : g_low
    assign hit = (c_ext <= l_ext);
  end
endmodule

// File: rtl/fifo_trig_port.sv
module fifo_trig_port
  import ftc_pkg::*;
#(
  parameter int                 DEPTH     = 128,
  parameter int                 DATA_W    = 8,
  parameter int                 ADDR_W    = 3,
  parameter logic [ADDR_W-1:0]  TRIG_ADDR = 3'd0,
  parameter logic [ADDR_W-1:0]  FEAT_ADDR = 3'd1,
  parameter logic [3*DATA_W-1:0] RX_FIXED = {8'd56, 8'd16, 8'd8},
  parameter logic [3*DATA_W-1:0] TX_FIXED = {8'd32, 8'd16, 8'd8},
  localparam int                CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [7:0]         lcr_val,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   tx_count,
  output logic [DATA_W-1:0]  rx_level,
  output logic [DATA_W-1:0]  tx_level,
  output logic               rx_hit,
  output logic               tx_hit,
  output logic [1:0]         rts_hyst
);
  logic unlocked, trig_sel, feat_sel;
  assign unlocked = (lcr_val == LCR_KEY);
  assign trig_sel = unlocked && (bus_addr == TRIG_ADDR);
  assign feat_sel = unlocked && (bus_addr == FEAT_ADDR);

  feat_t feat_q;
  logic [1:0][DATA_W-1:0] user_q;

  ftc_feat_reg u_feat (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr && feat_sel),
    .wdata (bus_wdata[7:0]),
    .feat_q(feat_q)
  );

  ftc_trig_bank #(.DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr && trig_sel),
    .dir_tx(feat_q.dir_tx),
    .wdata (bus_wdata),
    .user_q(user_q)
  );

  ftc_level_sel #(.DATA_W(DATA_W), .FIXED(RX_FIXED)) u_rx_sel (
    .tbl(feat_q.tbl), .user_lvl(user_q[0]), .level(rx_level)
  );
  ftc_level_sel #(.DATA_W(DATA_W), .FIXED(TX_FIXED)) u_tx_sel (
    .tbl(feat_q.tbl), .user_lvl(user_q[1]), .level(tx_level)
  );

  ftc_thresh #(.DATA_W(DATA_W), .CNT_W(CNT_W), .AT_HIGH(1'b1)) u_rx_cmp (
    .count(rx_count), .level(rx_level), .hit(rx_hit)
  );
  ftc_thresh #(.DATA_W(DATA_W), .CNT_W(CNT_W), .AT_HIGH(1'b0)) u_tx_cmp (
    .count(tx_count), .level(tx_level), .hit(tx_hit)
  );

  assign rts_hyst = feat_q.hyst;

  logic [CNT_W-1:0] sel_count;
  assign sel_count = feat_q.dir_tx ? tx_count : rx_count;

  always_comb begin
    bus_rdata = '0;
    if (trig_sel)      bus_rdata = DATA_W'(sel_count);
    else if (feat_sel) bus_rdata = DATA_W'(feat_q);
  end
endmodule

// File: rtl/fifo_trig_port_chk.sv
module fifo_trig_port_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [7:0]        lcr_val,
  input logic [CNT_W-1:0]  rx_count,
  input logic [CNT_W-1:0]  tx_count,
  input logic [DATA_W-1:0] rx_level,
  input logic [DATA_W-1:0] tx_level,
  input logic              rx_hit,
  input logic              tx_hit,
  input logic [7:0]        feat_q,
  input logic [1:0][DATA_W-1:0] user_q
);
  assert_rx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && lcr_val == 8'hBF && bus_addr == 3'd0 && !feat_q[7])
      |=> (user_q[0] == $past(bus_wdata)) && $stable(user_q[1]));

  assert_tx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && lcr_val == 8'hBF && bus_addr == 3'd0 && feat_q[7])
      |=> (user_q[1] == $past(bus_wdata)) && $stable(user_q[0]));

  assert_locked_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && lcr_val != 8'hBF) |=> $stable(user_q) && $stable(feat_q));

  assert_count_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_val == 8'hBF && bus_addr == 3'd0)
      |-> bus_rdata == (feat_q[7] ? DATA_W'(tx_count) : DATA_W'(rx_count)));

  assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_val != 8'hBF) |-> bus_rdata == '0);

  assert_user_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_q[5:4] == 2'b11) |-> (rx_level == user_q[0] && tx_level == user_q[1]));

  assert_rx_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(rx_count) > CNT_W'(rx_level)) |-> rx_hit);

  assert_tx_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> tx_hit);
endmodule

bind fifo_trig_port fifo_trig_port_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcr_val(lcr_val),
  .rx_count(rx_count), .tx_count(tx_count), .rx_level(rx_level),
  .tx_level(tx_level), .rx_hit(rx_hit), .tx_hit(tx_hit),
  .feat_q(feat_q), .user_q(user_q)
);

// File: tb/test_fifo_trig_port.sv
`timescale 1ns/1ps
module test_fifo_trig_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] lcr_val = '0;
  logic [7:0] rx_count = '0, tx_count = '0;
  logic [7:0] rx_level, tx_level;
  logic       rx_hit, tx_hit;
  logic [1:0] rts_hyst;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_feat = '0, m_rxu = '0, m_txu = '0;

  always #2.5 clk = ~clk;

  fifo_trig_port i_fifo_trig_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcr_val(lcr_val),
    .rx_count(rx_count), .tx_count(tx_count), .rx_level(rx_level),
    .tx_level(tx_level), .rx_hit(rx_hit), .tx_hit(tx_hit), .rts_hyst(rts_hyst)
  );

  function automatic logic [7:0] exp_level(bit tx, logic [1:0] tbl, logic [7:0] u);
    case (tbl)
      2'b00: return 8'd8;
      2'b01: return 8'd16;
      2'b10: return tx ? 8'd32 : 8'd56;
      default: return u;
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata(logic [7:0] lcr, logic [2:0] a);
    if (lcr != 8'hBF) return 8'h00;
    if (a == 3'd0) return m_feat[7] ? tx_count : rx_count;
    if (a == 3'd1) return m_feat;
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // compare all status outputs with the model (R6, R7, R8, R9)
  task automatic chk_outputs();
    logic [7:0] rl, tl;
    rl = exp_level(1'b0, m_feat[5:4], m_rxu);
    tl = exp_level(1'b1, m_feat[5:4], m_txu);
    chk("R6 rx_level", rx_level, rl);
    chk("R6 tx_level", tx_level, tl);
    chk("R7 rx_hit", {7'd0, rx_hit}, {7'd0, rx_count >= rl});
    chk("R8 tx_hit", {7'd0, tx_hit}, {7'd0, tx_count <= tl});
    chk("R9 rts_hyst", {6'd0, rts_hyst}, {6'd0, m_feat[1:0]});
  endtask

  task automatic do_write(logic [7:0] lcr, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    lcr_val = lcr; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (lcr == 8'hBF) begin
      if (a == 3'd1) m_feat = d;
      else if (a == 3'd0) begin
        if (m_feat[7]) m_txu = d; else m_rxu = d;
      end
    end
    #0.5;
    chk_outputs();
  endtask

  task automatic do_read(logic [7:0] lcr, logic [2:0] a, string tag);
    @(negedge clk);
    lcr_val = lcr; bus_addr = a;
    #0.5;
    chk(tag, bus_rdata, exp_rdata(lcr, a));
  endtask

  task automatic set_counts(logic [7:0] r, logic [7:0] t);
    @(negedge clk);
    rx_count = r; tx_count = t;
    #0.5;
    chk_outputs();
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    lcr_val = 8'hBF; bus_addr = 3'd1;
    #0.5;
    chk("R1 feature reset", bus_rdata, 8'h00);
    chk_outputs();
    do_write(8'hBF, 3'd1, 8'h30);          // select user table
    chk("R1 rx user reset", rx_level, 8'h00);
    chk("R1 tx user reset", tx_level, 8'h00);

    // R2 directed: load RX then TX
    do_write(8'hBF, 3'd0, 8'h22);
    chk("R2 rx load", rx_level, 8'h22);
    chk("R2 tx untouched", tx_level, 8'h00);
    do_write(8'hBF, 3'd1, 8'hB0);
    do_write(8'hBF, 3'd0, 8'h41);
    chk("R2 tx load", tx_level, 8'h41);
    chk("R2 rx untouched", rx_level, 8'h22);

    // R3 full count, both directions
    set_counts(8'd128, 8'd5);
    do_read(8'hBF, 3'd0, "R3 tx count");
    do_write(8'hBF, 3'd1, 8'h30);
    do_read(8'hBF, 3'd0, "R3 rx full 0x80");
    chk("R3 full literal", bus_rdata, 8'h80);

    // R4 locked writes ignored
    do_write(8'h03, 3'd0, 8'h99);
    chk("R4 rx kept", rx_level, 8'h22);
    do_write(8'h00, 3'd1, 8'h80);
    do_read(8'hBF, 3'd1, "R4 feature kept");

    // R5 locked and unmapped reads
    do_read(8'h3F, 3'd0, "R5 locked read");
    do_read(8'hBF, 3'd5, "R5 unmapped read");

    // R7/R8 boundaries on user levels
    set_counts(8'h22, 8'h41);   // equal: both hit
    set_counts(8'h21, 8'h42);   // one away: neither
    set_counts(8'd0, 8'd0);

    // R6 each fixed table
    for (int t = 0; t < 3; t++) begin
      do_write(8'hBF, 3'd1, {2'b00, 2'(t), 4'h0});
      set_counts(8'd16, 8'd16);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] lcr;
      op  = $urandom_range(0, 3);
      lcr = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'hBF;
      case (op)
        0: do_write(lcr, 3'd1, 8'($urandom));
        1: do_write(lcr, 3'd0, 8'($urandom_range(0, 130)));
        2: begin
             logic [7:0] r, t;
             r = 8'($urandom_range(0, 128));
             t = 8'($urandom_range(0, 128));
             if (t == r) t = (r == 8'd128) ? 8'd0 : r + 8'd1;
             set_counts(r, t);
           end
        default: do_read(lcr, 3'($urandom_range(0, 7)), "R3 R5 R9 random read");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule